// File: doc/BRIEF.md
# Three-Wire Serial Clock Slave with Port Wrapper

This block sits behind a 4-bit general-purpose port and acts as the slave end of a three-wire serial clock interface. The host sets a direction mask and then writes pin values to the port data register. Each write is masked by the direction register and handed to the serial engine. The engine returns a pin value, and the port stores that returned value. As a result, the slave can place read data on the serial data pin, and the host sees it when it reads the port back.

A transaction has three parts. First the host makes chip select rise while the clock pin is high. It then clocks in a command byte, and after that whole data bytes move in or out. The command selects the control byte, the full seven-byte date/time set or the three-byte time subset. The clock bytes are plain loadable storage. This block does not count time.

Top module: `rtc3w_port_top`

## Requirements
- R1: After rst_ni, the port data, direction and control registers and abort_o are all zero. A direction write stores wr_val_i, and a port-control write stores wr_val_i[0].
- R2: The port pins are SCK = bit 0, SIO = bit 1, CS = bit 2. A data write is ANDed with the direction register before the slave sees it. The value stored in the data register is the one the slave returns.
- R3: From idle, command capture starts only when the stored SCK is 1, the stored CS is 0 and the new CS is 1. A CS rise while SCK is low starts nothing.
- R4: SIO is sampled only on an SCK rise (stored 0, new 1). Bits fill each byte least significant bit first.
- R5: If the upper nibble of the received command byte is 6, the byte is decoded as it is. Otherwise the whole byte is bit-reversed first.
- R6: In the decoded command, bit 0 selects the direction (0 = write, 1 = read) and bits [3:1] select the target. Code 3 is the control byte (1 byte). Code 2 is date/time (7 bytes: year, month, day, weekday, hour, minute, second). Code 6 is time (3 bytes: hour, minute, second), and these share storage with date/time bytes 4 to 6.
- R7: In a write, each completed byte is stored at the current byte position. After the target's byte count the slave returns to idle and ignores further SCK edges.
- R8: In a read, each SCK rise drives the next bit of the current byte, LSB first, onto SIO of the stored port value.
- R9: Select code 0 clears the control byte and returns to idle. Any select code other than 0, 2, 3 or 6 returns to idle with no transfer.
- R10: A pulse on rtc_reset_i clears the control byte and leaves the date/time bytes unchanged.
- R11: If CS is low on a port write during the command or data phase, the slave returns to idle with its bit and byte counters cleared, and abort_o is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_en_i | input | 1 | Write wr_val_i to the port data register (masked, passed to slave) |
| wr_dir_en_i | input | 1 | Write wr_val_i to the direction register |
| wr_ctl_en_i | input | 1 | Write wr_val_i[0] to the port control bit |
| wr_val_i | input | 4 | Write value for the port registers |
| rtc_reset_i | input | 1 | Clears the clock control byte |
| port_data_o | output | 4 | Stored port data (pin state returned by slave) |
| port_dir_o | output | 4 | Direction register |
| port_ctl_o | output | 1 | Port control bit |
| abort_o | output | 1 | One-cycle pulse when a transaction is cut short by CS low |

## Verification
The hardest case to reach is a CS drop in the middle of a multi-byte write. At that point one byte is already committed and the next is half shifted. The bench drives the port bit by bit to that point, checks the abort pulse, and then reads date/time back. The read must show the first byte stored, the rest unchanged, and the byte counter starting again at zero. A second case needs care: a CS rise while SCK is low, followed by a full command and data byte. The host can only detect that this was ignored by reading the control byte back afterwards.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WR, ST_RD} st_e;
  typedef enum logic [1:0] {TGT_CTL, TGT_DT, TGT_TM} tgt_e;
endpackage

// File: rtl/rtc3w_cmd_dec.sv
module rtc3w_cmd_dec
  import rtc3w_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter logic [3:0]  MARKER = 4'h6
) (
  input  logic [BYTE_W-1:0] raw_i,
  output logic              valid_o,
  output logic              is_read_o,
  output logic              clr_ctl_o,
  output tgt_e              tgt_o
);
  localparam int NIB = 4;

  logic [NIB-1:0] rev_hi;
  logic [NIB-1:0] lo;

  // low nibble after reversal is the mirrored high nibble
  for (genvar g = 0; g < NIB; g++) begin : g_rev
    assign rev_hi[g] = raw_i[BYTE_W-1-g];
  end

  assign lo        = (raw_i[BYTE_W-1 -: NIB] == MARKER) ? raw_i[NIB-1:0] : rev_hi;
  assign is_read_o = lo[0];

  always_comb begin
    valid_o   = 1'b1;
    clr_ctl_o = 1'b0;
    tgt_o     = TGT_CTL;
    unique case (lo[3:1])
      3'd0:    begin valid_o = 1'b0; clr_ctl_o = 1'b1; end
      3'd2:    tgt_o = TGT_DT;
      3'd3:    tgt_o = TGT_CTL;
      3'd6:    tgt_o = TGT_TM;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc3w_regfile.sv
module rtc3w_regfile
  import rtc3w_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_DT    = 7,
  parameter int TIME_BASE = 4,
  parameter int IDX_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rtc_rst_i,
  input  logic              clr_ctl_i,
  input  logic              wr_en_i,
  input  tgt_e              tgt_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic [BYTE_W-1:0] ctl_o
);
  logic [BYTE_W-1:0] dt_q [NUM_DT];
  logic [BYTE_W-1:0] ctl_q;
  logic [IDX_W-1:0]  addr;

  assign addr  = (tgt_i == TGT_TM) ? IDX_W'(idx_i + IDX_W'(TIME_BASE)) : idx_i;
  assign ctl_o = ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                ctl_q <= '0;
    else if (rtc_rst_i || clr_ctl_i)            ctl_q <= '0;
    else if (wr_en_i && tgt_i == TGT_CTL)       ctl_q <= wr_byte_i;
  end

  for (genvar g = 0; g < NUM_DT; g++) begin : g_dt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        dt_q[g] <= '0;
      else if (wr_en_i && tgt_i != TGT_CTL && addr == IDX_W'(g))
        dt_q[g] <= wr_byte_i;
    end
  end

  always_comb begin
    rd_byte_o = '0;
    if (tgt_i == TGT_CTL) rd_byte_o = ctl_q;
    else if (int'(addr) < NUM_DT) rd_byte_o = dt_q[addr];
  end
endmodule

// File: rtl/rtc3w_engine.sv
module rtc3w_engine
  import rtc3w_pkg::*;
#(
  parameter int          PIN_W   = 4,
  parameter int          SCK_BIT = 0,
  parameter int          SIO_BIT = 1,
  parameter int          CS_BIT  = 2,
  parameter int          BYTE_W  = 8,
  parameter int          NUM_DT  = 7,
  parameter int          NUM_TM  = 3,
  parameter int          IDX_W   = 3,
  parameter logic [3:0]  MARKER  = 4'h6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [PIN_W-1:0]  prev_i,
  input  logic [PIN_W-1:0]  new_i,
  output logic [PIN_W-1:0]  ret_o,
  output logic              wr_en_o,
  output logic              clr_ctl_o,
  output tgt_e              tgt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              abort_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int LEN_W = IDX_W + 1;

  st_e               st_q, st_d;
  tgt_e              tgt_q, tgt_d;
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [IDX_W-1:0]  byte_q, byte_d;
  logic              abort_q, abort_d;

  logic              dec_valid, dec_rd, dec_clr;
  tgt_e              dec_tgt;
  logic              sck_rise, last_bit, last_byte;
  logic [LEN_W-1:0]  len, byte_nx;

  rtc3w_cmd_dec #(.BYTE_W(BYTE_W), .MARKER(MARKER)) u_dec (
    .raw_i    (buf_d),
    .valid_o  (dec_valid),
    .is_read_o(dec_rd),
    .clr_ctl_o(dec_clr),
    .tgt_o    (dec_tgt)
  );

  assign sck_rise  = !prev_i[SCK_BIT] && new_i[SCK_BIT];
  assign last_bit  = (bit_q == BIT_W'(BYTE_W - 1));
  assign len       = (tgt_q == TGT_CTL) ? LEN_W'(1) :
                     (tgt_q == TGT_DT)  ? LEN_W'(NUM_DT) : LEN_W'(NUM_TM);
  assign byte_nx   = {1'b0, byte_q} + LEN_W'(1);
  assign last_byte = (byte_nx == len);

  assign tgt_o     = tgt_q;
  assign idx_o     = byte_q;
  assign wr_byte_o = buf_d;
  assign abort_o   = abort_q;

  always_comb begin
    st_d      = st_q;
    tgt_d     = tgt_q;
    buf_d     = buf_q;
    bit_d     = bit_q;
    byte_d    = byte_q;
    abort_d   = 1'b0;
    ret_o     = new_i;
    wr_en_o   = 1'b0;
    clr_ctl_o = 1'b0;
    if (step_i) begin
      if (st_q != ST_IDLE && !new_i[CS_BIT]) begin
        st_d    = ST_IDLE;
        buf_d   = '0;
        bit_d   = '0;
        byte_d  = '0;
        abort_d = 1'b1;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (prev_i[SCK_BIT] && !prev_i[CS_BIT] && new_i[CS_BIT]) begin
              st_d  = ST_CMD;
              buf_d = '0;
              bit_d = '0;
            end
          end
          ST_CMD: begin
            if (sck_rise) begin
              buf_d[bit_q] = new_i[SIO_BIT];
              bit_d        = bit_q + BIT_W'(1);
              if (last_bit) begin
                bit_d     = '0;
                byte_d    = '0;
                tgt_d     = dec_tgt;
                clr_ctl_o = dec_clr;
                if (!dec_valid) st_d = ST_IDLE;
                else            st_d = dec_rd ? ST_RD : ST_WR;
              end
            end
          end
          ST_WR: begin
            if (sck_rise) begin
              buf_d[bit_q] = new_i[SIO_BIT];
              bit_d        = bit_q + BIT_W'(1);
              if (last_bit) begin
                wr_en_o = 1'b1;
                bit_d   = '0;
                byte_d  = byte_nx[IDX_W-1:0];
                if (last_byte) begin
                  byte_d = '0;
                  st_d   = ST_IDLE;
                end
              end
            end
          end
          ST_RD: begin
            if (sck_rise) begin
              ret_o[SIO_BIT] = rd_byte_i[bit_q];
              bit_d          = bit_q + BIT_W'(1);
              if (last_bit) begin
                bit_d  = '0;
                byte_d = byte_nx[IDX_W-1:0];
                if (last_byte) begin
                  byte_d = '0;
                  st_d   = ST_IDLE;
                end
              end
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tgt_q   <= TGT_CTL;
      buf_q   <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      buf_q   <= buf_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/rtc3w_port_top.sv
module rtc3w_port_top
  import rtc3w_pkg::*;
#(
  parameter int          PIN_W     = 4,
  parameter int          SCK_BIT   = 0,
  parameter int          SIO_BIT   = 1,
  parameter int          CS_BIT    = 2,
  parameter int          BYTE_W    = 8,
  parameter int          NUM_DT    = 7,
  parameter int          NUM_TM    = 3,
  parameter int          TIME_BASE = 4,
  parameter logic [3:0]  MARKER    = 4'h6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_data_en_i,
  input  logic             wr_dir_en_i,
  input  logic             wr_ctl_en_i,
  input  logic [PIN_W-1:0] wr_val_i,
  input  logic             rtc_reset_i,
  output logic [PIN_W-1:0] port_data_o,
  output logic [PIN_W-1:0] port_dir_o,
  output logic             port_ctl_o,
  output logic             abort_o
);
  localparam int IDX_W = $clog2(NUM_DT);

  logic [PIN_W-1:0]  data_q, dir_q, masked, ret;
  logic              pctl_q;
  logic              wr_en, clr_ctl;
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] wr_byte, rd_byte, rtc_ctl;

  assign masked = wr_val_i & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      pctl_q <= 1'b0;
    end else begin
      if (wr_data_en_i) data_q <= ret;
      if (wr_dir_en_i)  dir_q  <= wr_val_i;
      if (wr_ctl_en_i)  pctl_q <= wr_val_i[0];
    end
  end

  rtc3w_engine #(
    .PIN_W(PIN_W), .SCK_BIT(SCK_BIT), .SIO_BIT(SIO_BIT), .CS_BIT(CS_BIT),
    .BYTE_W(BYTE_W), .NUM_DT(NUM_DT), .NUM_TM(NUM_TM), .IDX_W(IDX_W), .MARKER(MARKER)
  ) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (wr_data_en_i),
    .prev_i   (data_q),
    .new_i    (masked),
    .ret_o    (ret),
    .wr_en_o  (wr_en),
    .clr_ctl_o(clr_ctl),
    .tgt_o    (tgt),
    .idx_o    (idx),
    .wr_byte_o(wr_byte),
    .rd_byte_i(rd_byte),
    .abort_o  (abort_o)
  );

  rtc3w_regfile #(
    .BYTE_W(BYTE_W), .NUM_DT(NUM_DT), .TIME_BASE(TIME_BASE), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rtc_rst_i(rtc_reset_i),
    .clr_ctl_i(clr_ctl),
    .wr_en_i  (wr_en),
    .tgt_i    (tgt),
    .idx_i    (idx),
    .wr_byte_i(wr_byte),
    .rd_byte_o(rd_byte),
    .ctl_o    (rtc_ctl)
  );

  assign port_data_o = data_q;
  assign port_dir_o  = dir_q;
  assign port_ctl_o  = pctl_q;
endmodule

// File: rtl/rtc3w_port_chk.sv
module rtc3w_port_chk #(
  parameter int PIN_W   = 4,
  parameter int SIO_BIT = 1,
  parameter int CS_BIT  = 2,
  parameter int BYTE_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_data_en_i,
  input logic              wr_dir_en_i,
  input logic [PIN_W-1:0]  wr_val_i,
  input logic              rtc_reset_i,
  input logic [PIN_W-1:0]  port_data_o,
  input logic [PIN_W-1:0]  port_dir_o,
  input logic              abort_o,
  input logic [BYTE_W-1:0] rtc_ctl
);
  localparam logic [PIN_W-1:0] SIO_M = PIN_W'(1) << SIO_BIT;

  // R2
  mask_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_en_i && !wr_dir_en_i) |=> ((port_data_o & ~port_dir_o & ~SIO_M) == '0));

  // R2
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_en_i |=> $stable(port_data_o));

  // R1
  dir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_en_i |=> (port_dir_o == $past(wr_val_i)));

  // R11
  abort_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> ($past(wr_data_en_i) && !($past(wr_val_i[CS_BIT]) && $past(port_dir_o[CS_BIT]))));

  // R11
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> (!abort_o || ($past(wr_data_en_i) && !port_data_o[CS_BIT])));

  // R10
  ctl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_reset_i |=> (rtc_ctl == '0));
endmodule

bind rtc3w_port_top rtc3w_port_chk #(
  .PIN_W(PIN_W), .SIO_BIT(SIO_BIT), .CS_BIT(CS_BIT), .BYTE_W(BYTE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_data_en_i(wr_data_en_i),
  .wr_dir_en_i (wr_dir_en_i),
  .wr_val_i    (wr_val_i),
  .rtc_reset_i (rtc_reset_i),
  .port_data_o (port_data_o),
  .port_dir_o  (port_dir_o),
  .abort_o     (abort_o),
  .rtc_ctl     (rtc_ctl)
);

// File: tb/rtc3w_port_top_tb.sv
`timescale 1ns/1ps
module rtc3w_port_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_data_en_i = 1'b0;
  logic       wr_dir_en_i = 1'b0;
  logic       wr_ctl_en_i = 1'b0;
  logic [3:0] wr_val_i = '0;
  logic       rtc_reset_i = 1'b0;
  logic [3:0] port_data_o, port_dir_o;
  logic       port_ctl_o, abort_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rtc3w_port_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_data_en_i(wr_data_en_i),
    .wr_dir_en_i(wr_dir_en_i), .wr_ctl_en_i(wr_ctl_en_i), .wr_val_i(wr_val_i),
    .rtc_reset_i(rtc_reset_i), .port_data_o(port_data_o), .port_dir_o(port_dir_o),
    .port_ctl_o(port_ctl_o), .abort_o(abort_o)
  );

  // command codes (marker-first form)
  localparam logic [7:0] C_WCTL = 8'h66, C_RCTL = 8'h67, C_WDT = 8'h64, C_RDT = 8'h65;
  localparam logic [7:0] C_WTM  = 8'h6C, C_RTM  = 8'h6D, C_RST = 8'h60, C_BAD = 8'h62;

  logic [7:0] dt_exp [7];

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  task automatic pwrite(logic [3:0] v);
    @(negedge clk_i); wr_data_en_i = 1'b1; wr_val_i = v;
    @(negedge clk_i); wr_data_en_i = 1'b0;
  endtask

  task automatic pin(logic cs, logic sio, logic sck);
    pwrite({1'b0, cs, sio, sck});
  endtask

  task automatic start();
    pin(1'b0, 1'b0, 1'b1);
    pin(1'b1, 1'b0, 1'b1);
  endtask

  task automatic stop();
    pin(1'b0, 1'b0, 1'b1);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      pin(1'b1, b[i], 1'b0);
      pin(1'b1, b[i], 1'b1);
    end
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      pin(1'b1, 1'b0, 1'b0);
      pin(1'b1, 1'b0, 1'b1);
      b[i] = port_data_o[1];
    end
  endtask

  task automatic read_ctl(string tag, logic [7:0] exp);
    logic [7:0] r;
    start(); send_byte(C_RCTL); recv_byte(r); stop();
    chk(tag, r, exp);
  endtask

  task automatic read_dt(string tag);
    logic [7:0] r;
    start(); send_byte(C_RDT);
    for (int k = 0; k < 7; k++) begin
      recv_byte(r);
      chk(tag, r, dt_exp[k]);
    end
    stop();
  endtask

  task automatic t_reset();
    chk("R1 data after reset", {4'h0, port_data_o}, 8'h00);
    chk("R1 dir after reset", {4'h0, port_dir_o}, 8'h00);
    chk("R1 ctl/abort after reset", {6'h0, port_ctl_o, abort_o}, 8'h00);
  endtask

  task automatic t_port();
    pwrite(4'hF);
    chk("R2 all masked", {4'h0, port_data_o}, 8'h00);
    @(negedge clk_i); wr_dir_en_i = 1'b1; wr_val_i = 4'h7;
    @(negedge clk_i); wr_dir_en_i = 1'b0;
    chk("R1 dir load", {4'h0, port_dir_o}, 8'h07);
    @(negedge clk_i); wr_ctl_en_i = 1'b1; wr_val_i = 4'h1;
    @(negedge clk_i); wr_ctl_en_i = 1'b0;
    chk("R1 port ctl", {7'h0, port_ctl_o}, 8'h01);
    pwrite(4'hF);
    chk("R2 bit3 masked", {4'h0, port_data_o}, 8'h07);
    stop();
  endtask

  task automatic t_ctl();
    start(); send_byte(C_WCTL); send_byte(8'hA5); stop();
    read_ctl("R4 R6 R8 ctl round trip", 8'hA5);
    start(); send_byte(rev8(C_WCTL)); send_byte(8'h3C); stop();
    begin
      logic [7:0] r;
      start(); send_byte(rev8(C_RCTL)); recv_byte(r); stop();
      chk("R5 reversed command", r, 8'h3C);
    end
  endtask

  task automatic t_dt();
    logic [7:0] v [7] = '{8'h22, 8'h05, 8'h17, 8'h03, 8'h12, 8'h34, 8'h56};
    logic [7:0] r;
    start(); send_byte(C_WDT);
    for (int k = 0; k < 7; k++) begin send_byte(v[k]); dt_exp[k] = v[k]; end
    stop();
    read_dt("R6 R7 date/time");
    start(); send_byte(C_WTM); send_byte(8'h08); send_byte(8'h09); send_byte(8'h10); stop();
    dt_exp[4] = 8'h08; dt_exp[5] = 8'h09; dt_exp[6] = 8'h10;
    read_dt("R6 time aliases date/time 4-6");
    start(); send_byte(C_RTM);
    for (int k = 0; k < 3; k++) begin recv_byte(r); chk("R6 time read", r, dt_exp[4+k]); end
    stop();
  endtask

  task automatic t_trail();
    start(); send_byte(C_WCTL); send_byte(8'h5A);
    send_byte(8'hFF);
    stop();
    read_ctl("R7 bits after last byte ignored", 8'h5A);
  endtask

  task automatic t_entry();
    pin(1'b0, 1'b0, 1'b0);
    pin(1'b1, 1'b0, 1'b0);
    send_byte(C_WCTL); send_byte(8'h11);
    stop();
    read_ctl("R3 CS rise with SCK low", 8'h5A);
  endtask

  task automatic t_codes();
    start(); send_byte(C_BAD); send_byte(8'h00); stop();
    read_ctl("R9 undefined select", 8'h5A);
    start(); send_byte(C_RST); stop();
    read_ctl("R9 reset select clears ctl", 8'h00);
    read_dt("R9 reset select keeps date/time");
  endtask

  task automatic t_rtcrst();
    start(); send_byte(C_WCTL); send_byte(8'h77); stop();
    @(negedge clk_i); rtc_reset_i = 1'b1;
    @(negedge clk_i); rtc_reset_i = 1'b0;
    read_ctl("R10 ctl cleared", 8'h00);
    read_dt("R10 date/time kept");
  endtask

  task automatic t_abort();
    start(); send_byte(C_WDT); send_byte(8'hAA);
    pin(1'b1, 1'b1, 1'b0); pin(1'b1, 1'b1, 1'b1);
    pin(1'b0, 1'b0, 1'b1);
    chk("R11 abort pulse", {7'h0, abort_o}, 8'h01);
    @(negedge clk_i);
    chk("R11 abort one cycle", {7'h0, abort_o}, 8'h00);
    dt_exp[0] = 8'hAA;
    read_dt("R11 partial write, counters cleared");
    start(); send_byte(C_RCTL);
    pin(1'b0, 1'b0, 1'b1);
    chk("R11 abort in read", {7'h0, abort_o}, 8'h01);
    start(); pin(1'b1, 1'b0, 1'b0); pin(1'b1, 1'b0, 1'b1);
    pin(1'b0, 1'b0, 1'b1);
    chk("R11 abort in command", {7'h0, abort_o}, 8'h01);
    read_ctl("R11 fresh command after abort", 8'h00);
  endtask

  initial begin
    for (int k = 0; k < 7; k++) dt_exp[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_port();
    t_ctl();
    t_dt();
    t_trail();
    t_entry();
    t_codes();
    t_rtcrst();
    t_abort();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule